// File: doc/BRIEF.md
# Dual-Format Serial Programming Port

This block is the host-facing programming port of a dual-loop frequency synthesizer. A host drives four slow pins: a serial clock, a main data line, an auxiliary data line and an enable. The block samples them with its own fast system clock. It shifts the data in on rising serial-clock edges and commits the assembled word to holding registers when the enable falls. The level that the enable holds while bits are clocked in sets the word class. With the enable high, the word is a control word or a reference-divider word, and its leading bit picks between the two. With the enable low, the word carries the transmit and receive channel divide ratios.

The channel ratios can arrive in two ways. In the three-wire form, all 32 bits come in on the main data line, transmit ratio first. In the four-wire form, the transmit ratio arrives on the auxiliary line while the receive ratio arrives on the main line, so the transfer takes 16 clocks. A bit in the control register picks the form. A frame whose length or identifier does not fit its class is dropped and sets a sticky error flag. The divider counters and phase detectors that use these registers sit outside this block.

Top module: `dualfmt_prog_port`

## Requirements
- R1: Data is sampled on rising serial-clock edges, and every word is sent most significant bit first.
- R2: The holding registers change only in the system cycle that follows a detected falling edge of the enable. While a word is still being clocked in, every output keeps its previous value.
- R3: With the enable high, an 8-clock word whose first bit is 1 is a control word. Its remaining bits, in order, are: test mode, four-wire select, host-clock divide-by-3 select, transmit power-down, receive power-down, reference power-down, and one reserved bit that is discarded.
- R4: With the enable high, a 32-clock word whose first bit is 0 is a reference word. After the identifier it carries, in order: the 12-bit reference ratio, the 14-bit auxiliary ratio, the auxiliary-enable bit, the 2-bit fr1 routing field, the receive reference-select bit and the transmit reference-select bit.
- R5: With four-wire select at 0, a channel word is 32 clocks with the enable low on the main data line. The 16-bit transmit ratio comes first and the 16-bit receive ratio follows. The auxiliary line has no effect.
- R6: With four-wire select at 1, a channel word is 16 clocks with the enable low. The transmit ratio bits come on the auxiliary line and the receive ratio bits on the main line in the same clocks.
- R7: A frame is discarded, with no register changed, when any of these holds: its length or leading bit does not match its class, or clocks arrived at both enable levels. A discarded frame sets the error flag, and only reset clears it.
- R8: Reset clears every register to zero. Transmit and receive power-down read 1 until the first valid channel word, and reference power-down reads 1 until the first valid reference word. After that point, each follows its control bit.
- R9: An enable pulse with no serial clocks changes no register and does not set the error flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Host serial clock (asynchronous) |
| sdin_i | input | 1 | Main serial data line |
| sadin_i | input | 1 | Auxiliary serial data line |
| sen_i | input | 1 | Serial enable: its level sets the word class, its falling edge commits |
| test_mode_o | output | 1 | Counter test-mode bit |
| four_wire_o | output | 1 | Four-wire channel loading selected |
| clkdiv3_o | output | 1 | Host clock divide-by-3 selected (0 selects divide-by-4) |
| tx_pd_o | output | 1 | Transmit chain power-down |
| rx_pd_o | output | 1 | Receive chain power-down |
| ref_pd_o | output | 1 | Reference counters power-down |
| ref_div_o | output | 12 | Reference divide ratio |
| aux_div_o | output | 14 | Auxiliary reference divide ratio |
| aux_en_o | output | 1 | Auxiliary reference counter enable |
| fr1_route_o | output | 2 | fr1 routing select |
| rx_ref_sel_o | output | 1 | Receive loop reference select |
| tx_ref_sel_o | output | 1 | Transmit loop reference select |
| tx_div_o | output | 16 | Transmit channel divide ratio |
| rx_div_o | output | 16 | Receive channel divide ratio |
| frame_err_o | output | 1 | Sticky malformed-frame flag |

## Verification
The bench sends words of every class and crosses them with the loading form: a three-wire channel word with noise on the auxiliary line, and a four-wire word with ratios at the extremes of the range. A swapped lane or a reversed bit order would show up as wrong transmit or receive ratios. It sends a bare enable pulse, a four-wire word one clock short, and a control-length word with a 0 identifier. A design that counted badly or ignored the identifier would overwrite registers or miss the error flag. It also checks the outputs while a word is still in flight, and follows the power-down outputs from reset through the first channel and reference loads. An early commit or a missing hold-off gate would make those outputs read wrong.

// File: rtl/ppp_pkg.sv
package ppp_pkg;

   localparam int REF_DIV_W = 12;
   localparam int AUX_DIV_W = 14;
   localparam int CHAN_W    = 16;
   localparam int ROUTE_W   = 2;
   localparam int CTL_LEN   = 8;
   localparam int REF_LEN   = 1 + REF_DIV_W + AUX_DIV_W + 1 + ROUTE_W + 2;
   localparam int CHAN_LEN  = 2 * CHAN_W;
   localparam int SHIFT_W   = (CHAN_LEN > REF_LEN) ? CHAN_LEN : REF_LEN;
   localparam int CNT_W     = $clog2(SHIFT_W + 1) + 1;

   typedef enum logic [2:0] {
      WK_NONE,
      WK_CTL,
      WK_REF,
      WK_CHAN,
      WK_BAD
   } word_kind_e;

   typedef struct packed {
      logic test;
      logic four_wire;
      logic div3;
      logic tx_pd;
      logic rx_pd;
      logic ref_pd;
   } ctl_t;

   typedef struct packed {
      logic [REF_DIV_W-1:0] ref_div;
      logic [AUX_DIV_W-1:0] aux_div;
      logic                 aux_en;
      logic [ROUTE_W-1:0]   route;
      logic                 rx_sel;
      logic                 tx_sel;
   } refw_t;

endpackage

// File: rtl/ppp_sync.sv
module ppp_sync #(
   parameter int W      = 4,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("ppp_sync needs at least two stages");
      end
   endgenerate

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[0] <= '0;
      else        stg[0] <= d;
   end

   generate
      for (genvar i = 1; i < STAGES; i++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= '0;
            else        stg[i] <= stg[i-1];
         end
      end
   endgenerate

   assign q = stg[STAGES-1];
endmodule

// File: rtl/ppp_shift.sv
module ppp_shift #(
   parameter int SHIFT_W = 32,
   parameter int LANE_W  = 16,
   parameter int CNT_W   = 7
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sclk_s,
   input  logic               din_s,
   input  logic               adin_s,
   input  logic               en_s,
   input  logic               four_wire,
   output logic               commit,
   output logic [SHIFT_W-1:0] main_sr,
   output logic [LANE_W-1:0]  aux_sr,
   output logic [CNT_W-1:0]   cnt_hi,
   output logic [CNT_W-1:0]   cnt_lo
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   generate
      if (LANE_W > SHIFT_W) begin : g_bad_lane
         $error("auxiliary lane wider than main shift register");
      end
      if ((1 << CNT_W) <= SHIFT_W + 1) begin : g_bad_cnt
         $error("bit counter too narrow");
      end
   endgenerate

   logic sclk_d, en_d;
   logic sclk_rise;

   assign sclk_rise = sclk_s & ~sclk_d;
   assign commit    = en_d & ~en_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d <= 1'b0;
         en_d   <= 1'b0;
      end else begin
         sclk_d <= sclk_s;
         en_d   <= en_s;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         main_sr <= '0;
         aux_sr  <= '0;
         cnt_hi  <= '0;
         cnt_lo  <= '0;
      end else if (commit) begin
         cnt_hi <= '0;
         cnt_lo <= '0;
      end else if (sclk_rise) begin
         main_sr <= {main_sr[SHIFT_W-2:0], din_s};
         if (en_s) begin
            if (cnt_hi != CNT_MAX) cnt_hi <= cnt_hi + 1'b1;
         end else begin
            if (four_wire) aux_sr <= {aux_sr[LANE_W-2:0], adin_s};
            if (cnt_lo != CNT_MAX) cnt_lo <= cnt_lo + 1'b1;
         end
      end
   end

   a_r1_hi_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk_rise && !commit && en_s && cnt_hi != CNT_MAX) |=> cnt_hi == $past(cnt_hi) + 1'b1);

   a_r2_clear_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> (cnt_hi == '0 && cnt_lo == '0));

   a_r1_no_shift_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!sclk_rise && !commit) |=> ($stable(main_sr) && $stable(cnt_lo) && $stable(cnt_hi)));
endmodule

// File: rtl/ppp_decode.sv
module ppp_decode
   import ppp_pkg::*;
#(
   parameter int SHIFT_W = 32,
   parameter int CNT_W   = 7,
   parameter int CTL_N   = 8,
   parameter int REF_N   = 32,
   parameter int LANE_N  = 16
) (
   input  logic [SHIFT_W-1:0] main_sr,
   input  logic [CNT_W-1:0]   cnt_hi,
   input  logic [CNT_W-1:0]   cnt_lo,
   input  logic               four_wire,
   output word_kind_e         kind
);
   localparam logic [CNT_W-1:0] CTL_CNT  = CNT_W'(CTL_N);
   localparam logic [CNT_W-1:0] REF_CNT  = CNT_W'(REF_N);
   localparam logic [CNT_W-1:0] C4_CNT   = CNT_W'(LANE_N);
   localparam logic [CNT_W-1:0] C3_CNT   = CNT_W'(2 * LANE_N);

   generate
      if (REF_N > SHIFT_W || CTL_N > SHIFT_W || 2 * LANE_N > SHIFT_W) begin : g_bad_len
         $error("word length exceeds shift register");
      end
   endgenerate

   logic hi_any, lo_any, chan_len_ok;

   assign hi_any      = |cnt_hi;
   assign lo_any      = |cnt_lo;
   assign chan_len_ok = four_wire ? (cnt_lo == C4_CNT) : (cnt_lo == C3_CNT);

   always_comb begin
      kind = WK_NONE;
      if (hi_any && lo_any) begin
         kind = WK_BAD;
      end else if (hi_any) begin
         if (cnt_hi == CTL_CNT && main_sr[CTL_N-1])       kind = WK_CTL;
         else if (cnt_hi == REF_CNT && !main_sr[REF_N-1]) kind = WK_REF;
         else                                             kind = WK_BAD;
      end else if (lo_any) begin
         kind = chan_len_ok ? WK_CHAN : WK_BAD;
      end
   end
endmodule

// File: rtl/ppp_regs.sv
module ppp_regs
   import ppp_pkg::*;
#(
   parameter int SHIFT_W = 32,
   parameter int LANE_W  = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               commit,
   input  word_kind_e         kind,
   input  logic [SHIFT_W-1:0] main_sr,
   input  logic [LANE_W-1:0]  aux_sr,
   output ctl_t               ctl_q,
   output refw_t              ref_q,
   output logic [LANE_W-1:0]  tx_q,
   output logic [LANE_W-1:0]  rx_q,
   output logic               chan_ld,
   output logic               ref_ld,
   output logic               frame_err
);
   localparam int CTL_FW = $bits(ctl_t);
   localparam int REF_FW = $bits(refw_t);

   generate
      if (REF_FW + 1 > SHIFT_W || 2 * LANE_W > SHIFT_W) begin : g_bad_fit
         $error("register fields do not fit the shift register");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q     <= '0;
         ref_q     <= '0;
         tx_q      <= '0;
         rx_q      <= '0;
         chan_ld   <= 1'b0;
         ref_ld    <= 1'b0;
         frame_err <= 1'b0;
      end else if (commit) begin
         case (kind)
            WK_CTL: ctl_q <= ctl_t'(main_sr[CTL_FW:1]);
            WK_REF: begin
               ref_q  <= refw_t'(main_sr[REF_FW-1:0]);
               ref_ld <= 1'b1;
            end
            WK_CHAN: begin
               rx_q    <= main_sr[LANE_W-1:0];
               tx_q    <= ctl_q.four_wire ? aux_sr : main_sr[2*LANE_W-1:LANE_W];
               chan_ld <= 1'b1;
            end
            WK_BAD:  frame_err <= 1'b1;
            default: ;
         endcase
      end
   end

   a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err |=> frame_err);

   a_r7_bad_discard: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && kind == WK_BAD) |=> ($stable(ctl_q) && $stable(ref_q) && $stable(tx_q) && $stable(rx_q)));

   a_r2_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> ($stable(ctl_q) && $stable(ref_q) && $stable(tx_q) && $stable(rx_q)));

   a_r9_empty_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && kind == WK_NONE) |=> ($stable(frame_err) && $stable(ctl_q) && $stable(tx_q)));

   a_r8_loaded_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_ld && ref_ld) |=> (chan_ld && ref_ld));
endmodule

// File: rtl/dualfmt_prog_port.sv
module dualfmt_prog_port
   import ppp_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sclk_i,
   input  logic                 sdin_i,
   input  logic                 sadin_i,
   input  logic                 sen_i,
   output logic                 test_mode_o,
   output logic                 four_wire_o,
   output logic                 clkdiv3_o,
   output logic                 tx_pd_o,
   output logic                 rx_pd_o,
   output logic                 ref_pd_o,
   output logic [REF_DIV_W-1:0] ref_div_o,
   output logic [AUX_DIV_W-1:0] aux_div_o,
   output logic                 aux_en_o,
   output logic [ROUTE_W-1:0]   fr1_route_o,
   output logic                 rx_ref_sel_o,
   output logic                 tx_ref_sel_o,
   output logic [CHAN_W-1:0]    tx_div_o,
   output logic [CHAN_W-1:0]    rx_div_o,
   output logic                 frame_err_o
);
   localparam int PIN_N = 4;

   logic [PIN_N-1:0]   pins_s;
   logic               sclk_s, din_s, adin_s, en_s;
   logic               commit;
   logic [SHIFT_W-1:0] main_sr;
   logic [CHAN_W-1:0]  aux_sr;
   logic [CNT_W-1:0]   cnt_hi, cnt_lo;
   word_kind_e         kind;
   ctl_t               ctl_q;
   refw_t              ref_q;
   logic               chan_ld, ref_ld;

   ppp_sync #(.W(PIN_N), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({sclk_i, sdin_i, sadin_i, sen_i}),
      .q     (pins_s)
   );

   assign {sclk_s, din_s, adin_s, en_s} = pins_s;

   ppp_shift #(.SHIFT_W(SHIFT_W), .LANE_W(CHAN_W), .CNT_W(CNT_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .sclk_s    (sclk_s),
      .din_s     (din_s),
      .adin_s    (adin_s),
      .en_s      (en_s),
      .four_wire (ctl_q.four_wire),
      .commit    (commit),
      .main_sr   (main_sr),
      .aux_sr    (aux_sr),
      .cnt_hi    (cnt_hi),
      .cnt_lo    (cnt_lo)
   );

   ppp_decode #(
      .SHIFT_W(SHIFT_W), .CNT_W(CNT_W), .CTL_N(CTL_LEN), .REF_N(REF_LEN), .LANE_N(CHAN_W)
   ) u_decode (
      .main_sr   (main_sr),
      .cnt_hi    (cnt_hi),
      .cnt_lo    (cnt_lo),
      .four_wire (ctl_q.four_wire),
      .kind      (kind)
   );

   ppp_regs #(.SHIFT_W(SHIFT_W), .LANE_W(CHAN_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .commit    (commit),
      .kind      (kind),
      .main_sr   (main_sr),
      .aux_sr    (aux_sr),
      .ctl_q     (ctl_q),
      .ref_q     (ref_q),
      .tx_q      (tx_div_o),
      .rx_q      (rx_div_o),
      .chan_ld   (chan_ld),
      .ref_ld    (ref_ld),
      .frame_err (frame_err_o)
   );

   assign test_mode_o  = ctl_q.test;
   assign four_wire_o  = ctl_q.four_wire;
   assign clkdiv3_o    = ctl_q.div3;
   assign tx_pd_o      = ctl_q.tx_pd  | ~chan_ld;
   assign rx_pd_o      = ctl_q.rx_pd  | ~chan_ld;
   assign ref_pd_o     = ctl_q.ref_pd | ~ref_ld;
   assign ref_div_o    = ref_q.ref_div;
   assign aux_div_o    = ref_q.aux_div;
   assign aux_en_o     = ref_q.aux_en;
   assign fr1_route_o  = ref_q.route;
   assign rx_ref_sel_o = ref_q.rx_sel;
   assign tx_ref_sel_o = ref_q.tx_sel;

   a_r8_pd_reset_release: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(commit) && $past(tx_pd_o) && $past(rx_pd_o)) |-> (tx_pd_o && rx_pd_o));
endmodule

// File: tb/dualfmt_prog_port_test.sv
module dualfmt_prog_port_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sclk = 1'b0, sdin = 1'b0, sadin = 1'b0, sen = 1'b0;

   logic        test_mode_o, four_wire_o, clkdiv3_o, tx_pd_o, rx_pd_o, ref_pd_o;
   logic [11:0] ref_div_o;
   logic [13:0] aux_div_o;
   logic        aux_en_o;
   logic [1:0]  fr1_route_o;
   logic        rx_ref_sel_o, tx_ref_sel_o;
   logic [15:0] tx_div_o, rx_div_o;
   logic        frame_err_o;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   dualfmt_prog_port uut (
      .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdin_i(sdin), .sadin_i(sadin), .sen_i(sen),
      .test_mode_o(test_mode_o), .four_wire_o(four_wire_o), .clkdiv3_o(clkdiv3_o),
      .tx_pd_o(tx_pd_o), .rx_pd_o(rx_pd_o), .ref_pd_o(ref_pd_o),
      .ref_div_o(ref_div_o), .aux_div_o(aux_div_o), .aux_en_o(aux_en_o),
      .fr1_route_o(fr1_route_o), .rx_ref_sel_o(rx_ref_sel_o), .tx_ref_sel_o(tx_ref_sel_o),
      .tx_div_o(tx_div_o), .rx_div_o(rx_div_o), .frame_err_o(frame_err_o)
   );

   typedef struct {
      logic        test, fw, div3, txpd, rxpd, refpd;
      logic [11:0] refd;
      logic [13:0] auxd;
      logic        auxen;
      logic [1:0]  route;
      logic        rxsel, txsel;
      logic [15:0] tx, rx;
      logic        err;
      string       step;
   } exp_t;

   exp_t q[$];

   // bench model
   logic [5:0]  m_ctl = '0;
   logic [30:0] m_ref = '0;
   logic [15:0] m_tx = '0, m_rx = '0;
   logic        m_chan_ld = 1'b0, m_ref_ld = 1'b0, m_err = 1'b0;

   function automatic exp_t mk(string step);
      exp_t e;
      e.test  = m_ctl[5];
      e.fw    = m_ctl[4];
      e.div3  = m_ctl[3];
      e.txpd  = m_ctl[2] | ~m_chan_ld;
      e.rxpd  = m_ctl[1] | ~m_chan_ld;
      e.refpd = m_ctl[0] | ~m_ref_ld;
      e.refd  = m_ref[30:19];
      e.auxd  = m_ref[18:5];
      e.auxen = m_ref[4];
      e.route = m_ref[3:2];
      e.rxsel = m_ref[1];
      e.txsel = m_ref[0];
      e.tx    = m_tx;
      e.rx    = m_rx;
      e.err   = m_err;
      e.step  = step;
      return e;
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] expv);
      checks++;
      if (act !== expv) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, expv);
      end
   endtask

   task automatic cmp(exp_t e);
      chk({e.step, " R3 test"},      32'(test_mode_o),  32'(e.test));
      chk({e.step, " R3 four_wire"}, 32'(four_wire_o),  32'(e.fw));
      chk({e.step, " R3 div3"},      32'(clkdiv3_o),    32'(e.div3));
      chk({e.step, " R8 tx_pd"},     32'(tx_pd_o),      32'(e.txpd));
      chk({e.step, " R8 rx_pd"},     32'(rx_pd_o),      32'(e.rxpd));
      chk({e.step, " R8 ref_pd"},    32'(ref_pd_o),     32'(e.refpd));
      chk({e.step, " R4 ref_div"},   32'(ref_div_o),    32'(e.refd));
      chk({e.step, " R4 aux_div"},   32'(aux_div_o),    32'(e.auxd));
      chk({e.step, " R4 sel"},       {27'd0, aux_en_o, fr1_route_o, rx_ref_sel_o, tx_ref_sel_o},
                                     {27'd0, e.auxen, e.route, e.rxsel, e.txsel});
      chk({e.step, " R1 R5 R6 tx"},  32'(tx_div_o),     32'(e.tx));
      chk({e.step, " R1 R5 R6 rx"},  32'(rx_div_o),     32'(e.rx));
      chk({e.step, " R7 err"},       32'(frame_err_o),  32'(e.err));
   endtask

   // monitor: pops expected snapshots once the committed result has settled
   initial begin
      forever begin
         wait (q.size() > 0);
         repeat (12) @(posedge clk);
         @(negedge clk);
         cmp(q[0]);
         void'(q.pop_front());
      end
   end

   task automatic expect_now(string step);
      q.push_back(mk(step));
      wait (q.size() == 0);
   endtask

   task automatic sbit(input logic d, input logic a);
      @(negedge clk);
      sdin  = d;
      sadin = a;
      repeat (4) @(negedge clk);
      sclk = 1'b1;
      repeat (4) @(negedge clk);
      sclk = 1'b0;
   endtask

   task automatic send_hi(input logic [31:0] w, input int n, input bit hold_chk);
      @(negedge clk);
      sen = 1'b1;
      repeat (4) @(negedge clk);
      for (int i = n - 1; i >= 0; i--) sbit(w[i], 1'b0);
      repeat (12) @(negedge clk);
      if (hold_chk) begin
         exp_t h;
         h = mk("hold before enable fall R2");
         cmp(h);
      end
      sen = 1'b0;
   endtask

   task automatic pulse_en();
      repeat (4) @(negedge clk);
      sen = 1'b1;
      repeat (4) @(negedge clk);
      sen = 1'b0;
   endtask

   task automatic send_3w(input logic [15:0] tx, input logic [15:0] rx);
      for (int i = 15; i >= 0; i--) sbit(tx[i], ~tx[i]);
      for (int i = 15; i >= 0; i--) sbit(rx[i], i[0]);
      pulse_en();
   endtask

   task automatic send_4w(input logic [15:0] tx, input logic [15:0] rx, input int n);
      for (int i = 15; i >= 16 - n; i--) sbit(rx[i], tx[i]);
      pulse_en();
   endtask

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      expect_now("reset R8");

      // R3: control word, div3 set; pd still held (R8)
      send_hi(32'h90, 8, 1'b1);
      m_ctl = 6'b001000;
      expect_now("ctl div3 R3");

      // R4: reference word
      send_hi({1'b0, 12'hA5C, 14'h1234, 1'b1, 2'b10, 1'b1, 1'b0}, 32, 1'b0);
      m_ref = {12'hA5C, 14'h1234, 1'b1, 2'b10, 1'b1, 1'b0};
      m_ref_ld = 1'b1;
      expect_now("ref word R4");

      // R5: three-wire channel word, aux line toggling
      send_3w(16'hC3A5, 16'h5E17);
      m_tx = 16'hC3A5; m_rx = 16'h5E17; m_chan_ld = 1'b1;
      expect_now("3wire R5");

      // R3: four-wire select and transmit power-down
      send_hi(32'hA8, 8, 1'b0);
      m_ctl = 6'b010100;
      expect_now("ctl fw txpd R3");

      // R6: four-wire channel word with boundary values
      send_4w(16'h8001, 16'hFFFE, 16);
      m_tx = 16'h8001; m_rx = 16'hFFFE;
      expect_now("4wire R6");

      // R9: bare enable pulse
      pulse_en();
      expect_now("bare pulse R9");

      // R7: four-wire word one clock short
      send_4w(16'h1111, 16'h2222, 15);
      m_err = 1'b1;
      expect_now("short frame R7");

      // R7: control-length word with 0 identifier
      send_hi(32'h46, 8, 1'b0);
      expect_now("bad id R7");

      // R7 sticky, R8: valid control word after error, rx/ref powered down
      send_hi(32'h86, 8, 1'b0);
      m_ctl = 6'b000011;
      expect_now("ctl after err R7 R8");

      // R3: test bit, all power-down bits cleared
      send_hi(32'hC0, 8, 1'b0);
      m_ctl = 6'b100000;
      expect_now("ctl test R3");

      // R5: back in three-wire mode, new ratios
      send_3w(16'h0001, 16'h8000);
      m_tx = 16'h0001; m_rx = 16'h8000;
      expect_now("3wire again R5");

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule